// File: doc/BRIEF.md
# Skid-buffered pipeline register stage

This block is one register stage for a streaming datapath. A word enters through a valid/ready pair on the upstream side and leaves through a valid/ready pair on the downstream side. The data passes through unchanged, and the data width is a parameter. As long as the downstream side keeps taking data, the stage moves one word per clock.

The upstream ready is presented in negated form as `up_busy`. That signal comes straight from a flop, so the upstream ready has no combinational path from `dn_ready`. This costs one extra data register, the side buffer. Suppose the stage accepts a word in the same cycle that the downstream side first refuses. That word cannot go to the output register, which still holds an unconsumed word. It goes into the side buffer instead, and `up_busy` rises on that edge.

Back-pressure follows these rules:
- A word transfers upstream on a clock edge where `up_valid` is 1 and `up_busy` is 0.
- A word transfers downstream on a clock edge where `dn_valid` and `dn_ready` are both 1.
- `up_valid` and `dn_ready` may be raised whatever the other side is doing.
- `up_valid` is ignored while `up_busy` is 1.

Stages can be chained directly, each stage's `dn_ready` driven by the next stage's negated `up_busy`.

Top module: `skid_stage`

## Requirements
- R1: An active-low asynchronous reset `rst_n` clears `dn_valid`, `up_busy` and the side buffer at once, without waiting for a clock edge.
- R2: When the stage is not busy and its output slot is free (`dn_valid`=0 or `dn_ready`=1), a word offered with `up_valid`=1 appears on `dn_data` with `dn_valid`=1 after the next edge. With `dn_ready` held at 1, the stage sustains one word per clock.
- R3: A word accepted while `dn_valid`=1 and `dn_ready`=0 is kept in the side buffer, and `up_busy` is 1 after that edge.
- R4: `up_busy` is a registered output. A change of `dn_ready` between clock edges does not change it.
- R5: While `dn_valid`=1 and `dn_ready`=0, `dn_valid` stays 1 and `dn_data` does not change at the next edge.
- R6: With the buffer full and `dn_ready`=1, the buffered word moves to the output on that edge and `up_busy` falls on the same edge. Words offered while `up_busy`=1 are neither taken nor emitted.
- R7: The words leave in exactly the order they were accepted, with no duplicates and no drops, under any pattern of valid and ready, including through a chain of stages.
- R8: When the output word is consumed and no word is taken on the same edge, with the stage not busy, `dn_valid` is 0 after that edge.
- R9: `up_busy`=1 only while `dn_valid`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream word present |
| up_data | input | DATA_W | Upstream word |
| up_busy | output | 1 | Registered not-ready towards upstream |
| dn_valid | output | 1 | Downstream word present |
| dn_data | output | DATA_W | Downstream word |
| dn_ready | input | 1 | Downstream can take the word |

## Verification
The bound checker watches every cycle for these rules:
- the pass-through timing;
- buffer fill when a stall begins;
- the same-edge drain and busy release;
- the hold of output data while stalled;
- the valid drop after the last word;
- that busy never occurs without an output word.

Some behaviour only the bench's scenarios can show:
- that busy is unaffected by `dn_ready` between edges;
- that words offered during busy are really lost to the stream and never surface later;
- exact ordering with no loss across long random valid/ready patterns and a chain of three stages, compared against a scoreboard;
- the asynchronous nature of the reset.

// File: rtl/skid_pkg.sv
package skid_pkg;
  // Occupancy of the stage: nothing, output register only, output plus side buffer
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_ONE   = 2'd1,
    OCC_TWO   = 2'd2
  } occ_e;
endpackage

// File: rtl/skid_ctrl.sv
module skid_ctrl
  import skid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_valid,
  input  logic dn_ready,
  output logic busy,
  output logic out_valid,
  output logic load_out,
  output logic out_from_buf,
  output logic load_buf
);
  occ_e occ_q, occ_d;
  logic take;

  assign busy      = (occ_q == OCC_TWO);
  assign out_valid = (occ_q != OCC_EMPTY);
  assign take      = up_valid && !busy;

  always_comb begin
    occ_d        = occ_q;
    load_out     = 1'b0;
    out_from_buf = 1'b0;
    load_buf     = 1'b0;
    unique case (occ_q)
      OCC_EMPTY: begin
        if (take) begin
          occ_d    = OCC_ONE;
          load_out = 1'b1;
        end
      end
      OCC_ONE: begin
        if (dn_ready) begin
          if (take) load_out = 1'b1;
          else      occ_d    = OCC_EMPTY;
        end else if (take) begin
          load_buf = 1'b1;
          occ_d    = OCC_TWO;
        end
      end
      OCC_TWO: begin
        if (dn_ready) begin
          load_out     = 1'b1;
          out_from_buf = 1'b1;
          occ_d        = OCC_ONE;
        end
      end
      default: occ_d = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= OCC_EMPTY;
    else        occ_q <= occ_d;
  end
endmodule

// File: rtl/skid_regs.sv
module skid_regs #(
  parameter int unsigned DATA_W     = 32,
  parameter bit          CLEAR_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              load_out,
  input  logic              out_from_buf,
  input  logic              load_buf,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] out_q, buf_q, out_next;

  // The side buffer is written only from the input; the output register takes
  // either the input or the buffered word.
  assign out_next = out_from_buf ? buf_q : in_data;
  assign out_data = out_q;

  if (CLEAR_DATA) begin : g_clr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
        buf_q <= '0;
      end else begin
        if (load_out) out_q <= out_next;
        if (load_buf) buf_q <= in_data;
      end
    end
  end else begin : g_noclr
    always_ff @(posedge clk) begin
      if (load_out) out_q <= out_next;
      if (load_buf) buf_q <= in_data;
    end
  end
endmodule

// File: rtl/skid_stage.sv
module skid_stage #(
  parameter int unsigned DATA_W     = 32,
  parameter bit          CLEAR_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_busy,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_ready
);
  logic load_out, out_from_buf, load_buf;

  skid_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_valid     (up_valid),
    .dn_ready     (dn_ready),
    .busy         (up_busy),
    .out_valid    (dn_valid),
    .load_out     (load_out),
    .out_from_buf (out_from_buf),
    .load_buf     (load_buf)
  );

  skid_regs #(.DATA_W(DATA_W), .CLEAR_DATA(CLEAR_DATA)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_data      (up_data),
    .load_out     (load_out),
    .out_from_buf (out_from_buf),
    .load_buf     (load_buf),
    .out_data     (dn_data)
  );
endmodule

// File: rtl/skid_stage_chk.sv
module skid_stage_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic [DATA_W-1:0] up_data,
  input logic              up_busy,
  input logic              dn_valid,
  input logic [DATA_W-1:0] dn_data,
  input logic              dn_ready
);
  // R1: while reset is held, handshake outputs are low
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!dn_valid && !up_busy)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_busy && (!dn_valid || dn_ready)) |=> (dn_valid && dn_data == $past(up_data)));

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_busy && dn_valid && !dn_ready) |=> up_busy);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_busy && dn_ready) |=> (!up_busy && dn_valid));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !up_busy && !up_valid) |=> !dn_valid);

  p_busy_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    up_busy |-> dn_valid);
endmodule

bind skid_stage skid_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_data  (up_data),
  .up_busy  (up_busy),
  .dn_valid (dn_valid),
  .dn_data  (dn_data),
  .dn_ready (dn_ready)
);

// File: tb/skid_stage_test.sv
`timescale 1ns/1ps
module skid_stage_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_valid = 1'b0;
  logic [W-1:0] up_data = '0;
  logic         up_busy, dn_valid;
  logic [W-1:0] dn_data;
  logic         dn_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  skid_stage #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
    .up_busy(up_busy), .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready)
  );

  // Three-stage chain for R7
  logic         c_in_valid = 1'b0, c_out_ready = 1'b0;
  logic [W-1:0] c_in_data = '0;
  logic         b0, b1, b2, v0, v1, v2;
  logic [W-1:0] d0, d1, d2;

  skid_stage #(.DATA_W(W)) c0 (.clk(clk), .rst_n(rst_n), .up_valid(c_in_valid), .up_data(c_in_data),
    .up_busy(b0), .dn_valid(v0), .dn_data(d0), .dn_ready(!b1));
  skid_stage #(.DATA_W(W)) c1 (.clk(clk), .rst_n(rst_n), .up_valid(v0), .up_data(d0),
    .up_busy(b1), .dn_valid(v1), .dn_data(d1), .dn_ready(!b2));
  skid_stage #(.DATA_W(W), .CLEAR_DATA(1'b0)) c2 (.clk(clk), .rst_n(rst_n), .up_valid(v1), .up_data(d1),
    .up_busy(b2), .dn_valid(v2), .dn_data(d2), .dn_ready(c_out_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard for uut: handshakes observed at the edge
  logic [W-1:0] sb_q[$];
  bit sb_on = 1'b0;
  always @(posedge clk) begin
    if (sb_on && rst_n) begin
      if (dn_valid && dn_ready) begin
        if (sb_q.size() == 0) check(1'b0, "R7 unexpected word", int'(dn_data), 0);
        else begin
          logic [W-1:0] e;
          e = sb_q.pop_front();
          check(dn_data == e, "R7 order", int'(dn_data), int'(e));
        end
      end
      if (up_valid && !up_busy) sb_q.push_back(up_data);
    end
  end

  // Chain scoreboard: sequence numbers
  int c_sent = 0;
  int c_got = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (v2 && c_out_ready) begin
        check(int'(d2) == (c_got & 16'hffff), "R7 chain order", int'(d2), c_got & 16'hffff);
        c_got++;
      end
    end
  end

  task automatic drive(input bit v, input logic [W-1:0] d, input bit r);
    @(negedge clk);
    up_valid = v; up_data = d; dn_ready = r;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #20;
    check(!dn_valid && !up_busy, "R1 reset state", {dn_valid, up_busy}, 0);
    @(negedge clk); rst_n = 1'b1;
    // fill the stage, then reset asynchronously between edges
    drive(1'b1, 16'h1111, 1'b0);
    drive(1'b1, 16'h2222, 1'b0);
    check(up_busy && dn_valid, "R3 busy before async reset", {dn_valid, up_busy}, 3);
    @(negedge clk); up_valid = 1'b0; #1;
    sb_q.delete();
    rst_n = 1'b0; #1;
    check(!dn_valid && !up_busy, "R1 async clear", {dn_valid, up_busy}, 0);
    @(negedge clk); rst_n = 1'b1;
    // buffered word must be gone: next word is the first out
    drive(1'b1, 16'h3333, 1'b1);
    check(dn_valid && dn_data == 16'h3333, "R1 buffer cleared", int'(dn_data), 16'h3333);
    drive(1'b0, '0, 1'b1);
    check(!dn_valid, "R1 no stale word", dn_valid, 0);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 16'h0a00 + 16'(k), 1'b1);
      check(dn_valid && dn_data == 16'h0a00 + 16'(k), "R2 streaming word", int'(dn_data), 16'h0a00 + k);
      check(!up_busy, "R2 never busy while draining", up_busy, 0);
    end
    drive(1'b0, '0, 1'b1);
    check(!dn_valid, "R8 valid drops after last word", dn_valid, 0);
  endtask

  task automatic t_stall();
    drive(1'b1, 16'h00aa, 1'b1);
    check(dn_data == 16'h00aa, "R2 first word", int'(dn_data), 16'h00aa);
    drive(1'b1, 16'h00bb, 1'b0);
    check(up_busy, "R3 busy after stalled accept", up_busy, 1);
    check(dn_valid && dn_data == 16'h00aa, "R3 output unchanged", int'(dn_data), 16'h00aa);
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 16'h00cc, 1'b0);
      check(dn_valid && dn_data == 16'h00aa, "R5 hold while stalled", int'(dn_data), 16'h00aa);
      check(up_busy, "R6 still busy", up_busy, 1);
      check(dn_valid, "R9 busy with output word", dn_valid, 1);
    end
    dn_ready = 1'b1; #1;
    check(up_busy, "R4 busy unaffected by ready between edges", up_busy, 1);
    drive(1'b0, '0, 1'b1);
    check(dn_valid && dn_data == 16'h00bb, "R6 buffered word moves out", int'(dn_data), 16'h00bb);
    check(!up_busy, "R6 busy falls same edge", up_busy, 1'b0);
    drive(1'b0, '0, 1'b1);
    check(!dn_valid, "R6 word offered while busy not emitted", int'(dn_data), 0);
  endtask

  task automatic t_random();
    sb_on = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      up_valid = ($urandom % 4) != 0;
      up_data  = W'($urandom);
      dn_ready = ($urandom % 3) != 0;
    end
    @(negedge clk); up_valid = 1'b0; dn_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(sb_q.size() == 0, "R7 all words delivered", sb_q.size(), 0);
    sb_on = 1'b0;
  endtask

  task automatic t_chain();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      c_out_ready = ($urandom % 2) != 0;
      if (!(c_in_valid && !b0)) c_in_valid = ($urandom % 3) != 0;
      c_in_data = W'(c_sent);
      @(posedge clk);
      if (c_in_valid && !b0) c_sent++;
      #1;
      if (c_in_valid && !b0) ; // no-op, counting done above
    end
    @(negedge clk); c_in_valid = 1'b0; c_out_ready = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    check(c_got == c_sent, "R7 chain count", c_got, c_sent);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream();
    t_stall();
    t_random();
    t_chain();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule